// File: doc/BRIEF.md
# Three-Line Serial Configuration Receiver

This block is the configuration front end of a radio tuning synthesizer. A host controller drives three lines: a serial data line, a serial clock and a framing line. While the framing line is high, each falling edge of the serial clock shifts one data bit into a shift register, most significant bit first. When the framing line drops, the frame is judged. A frame with exactly eight clock falls is accepted. Its top two bits select one of four 6-bit destinations, and its low six bits are the payload. Any other bit count discards the frame.

The three lines are asynchronous to the fast system clock. They pass through a synchronizer chain, and all edges are detected in the system clock domain. A small state machine frames the transfer. It has three states:
- `S_IDLE` waits for the framing line to rise (transition `T_START`).
- `S_RECV` shifts bits in and counts clock falls, saturating one above the word length. It leaves on the framing line's fall (transition `T_END`).
- `S_CHECK` lasts one cycle. It accepts or rejects the word and always returns to `S_IDLE` (transition `T_DONE`).

A register bank decodes accepted words.
- The control fields take effect at once.
- The 8-bit main divisor is assembled in a staging register from two words. It reaches the output only when a swallow-count word arrives.
- That swallow-count word updates both divisor outputs together and raises a one-cycle commit strobe.
- When both mode bits are zero, the standby output is set. All register contents are kept.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset every field output, `pc_o` and `sc_o` are zero, `commit_o` is 0 and `standby_o` is 1.
- R2: A word is shifted in MSB first, one bit per falling edge of `ser_clk_i` while `ser_frame_i` is high. It is evaluated only after `ser_frame_i` falls, and its effect appears at the outputs within 12 system cycles of that fall.
- R3: An accepted word with address bits [7:6] = 00 loads the following fields from bits [5:0]:
  - bit 5 → `test_o[0]`, bit 4 → `test_o[1]`, bit 3 → `test_o[2]`;
  - bit 2 → `sw_out_o`;
  - bit 1 → `cp_cur_lo_o`;
  - bit 0 → `ref_sel_o`.
- R4: An accepted word with address 01 loads the following:
  - bit 3 → `lf_sel_o`, bit 2 → `cp_cur_hi_o`, bit 1 → `div_mode_o`, bit 0 → `band_o`, all immediately;
  - bits 5:4 → the staged divisor bits 7:6.
- R5: An accepted word with address 10 loads the staged divisor bits 5:0. `pc_o` does not change on an address 01 or 10 word.
- R6: An accepted word with address 11 loads `sc_o` from bits [5:0] and copies the staged divisor into `pc_o` in the same cycle. `commit_o` is high for exactly that one cycle.
- R7: A frame with any number of clock falls other than 8 (such as 7 or 9) changes no output and gives no commit.
- R8: `standby_o` is 1 exactly when `div_mode_o` and `band_o` are both 0. Entering and leaving standby keeps every register value.
- R9: Serial clock edges while `ser_frame_i` is low are ignored. Words may arrive in any order and any number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial clock; data taken on its falling edge |
| ser_frame_i | input | 1 | Frame enable; high while a word is sent |
| test_o | output | 3 | Test selection bits |
| sw_out_o | output | 1 | Switch output level |
| cp_cur_lo_o | output | 1 | Charge-pump current select, word-00 bit |
| ref_sel_o | output | 1 | Reference step select |
| lf_sel_o | output | 1 | Loop-filter input select |
| cp_cur_hi_o | output | 1 | Charge-pump current select, word-01 bit |
| div_mode_o | output | 1 | Swallow (1) / direct (0) mode |
| band_o | output | 1 | Band select, 1 = AM, 0 = FM |
| standby_o | output | 1 | Standby indication |
| pc_o | output | 8 | Committed main divisor |
| sc_o | output | 6 | Committed swallow count |
| commit_o | output | 1 | One-cycle strobe: take new divisor values |

## Verification
The bench builds the block with the default 8-bit word and a three-stage synchronizer (`SYNC_STAGES = 3`), instead of the default two. This gives the longest pin-to-output latency the checks must allow for. The serial clock half period is six system cycles. At that spacing every serial edge is seen after synchronization, and a 7-fall or 9-fall frame can sit between valid ones to test rejection. A staged divisor interleaved with control and standby words shows that commit happens only on the swallow-count word.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

    localparam int ADDR_BITS = 2;
    localparam int DATA_BITS = 6;
    localparam int WORD_BITS = ADDR_BITS + DATA_BITS;
    localparam int PC_BITS   = 8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RECV  = 2'd1,
        S_CHECK = 2'd2
    } rx_state_e;

    typedef enum logic [ADDR_BITS-1:0] {
        ADR_CTL_A = 2'b00,
        ADR_CTL_B = 2'b01,
        ADR_PC_LO = 2'b10,
        ADR_SC    = 2'b11
    } reg_addr_e;

endpackage

// File: rtl/serial_cfg_sync.sv
module serial_cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/serial_cfg_frame_rx.sv
module serial_cfg_frame_rx
    import serial_cfg_pkg::*;
#(
    parameter int NBITS = WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             frame_s,
    input  logic             data_s,
    output logic [NBITS-1:0] word_o,
    output logic             word_vld_o
);
    localparam int CNT_MAX = NBITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_e        state, state_nx;
    logic             sclk_q, frame_q;
    logic [NBITS-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             sclk_fall, frame_rise, frame_fall;

    assign sclk_fall  = sclk_q & ~sclk_s;
    assign frame_rise = ~frame_q & frame_s;
    assign frame_fall = frame_q & ~frame_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_START, T_END, T_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (frame_rise) state_nx = S_RECV;
            S_RECV:  if (frame_fall) state_nx = S_CHECK;
            S_CHECK: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_vld_o = 1'b0;
        unique case (state)
            S_CHECK: word_vld_o = (cnt == CNT_W'(NBITS));
            default: word_vld_o = 1'b0;
        endcase
    end

    assign word_o = shreg;

    // edge history, shifter and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            frame_q <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
        end else begin
            sclk_q  <= sclk_s;
            frame_q <= frame_s;
            if (state == S_IDLE && frame_rise) begin
                cnt <= '0;
            end else if (state == S_RECV && frame_s && sclk_fall) begin
                shreg <= {shreg[NBITS-2:0], data_s};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: the end of a frame always leads to the check state
    p_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECV && frame_fall) |=> (state == S_CHECK));

    // R7: the check lasts a single cycle
    p_check_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CHECK) |=> (state == S_IDLE));

    // R9: no bit is shifted outside a frame
    p_idle_no_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(shreg));
endmodule

// File: rtl/serial_cfg_reg_bank.sv
module serial_cfg_reg_bank
    import serial_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_BITS-1:0] word_i,
    input  logic                 word_vld_i,
    output logic [DATA_BITS-1:0] ctl_a_o,
    output logic [DATA_BITS-1:0] ctl_b_o,
    output logic [PC_BITS-1:0]   pc_o,
    output logic [DATA_BITS-1:0] sc_o,
    output logic                 commit_o
);
    localparam int PC_HI_BITS = PC_BITS - DATA_BITS;

    reg_addr_e            addr;
    logic [DATA_BITS-1:0] payload;
    logic [DATA_BITS-1:0] pc_lo_stg;

    assign addr    = reg_addr_e'(word_i[WORD_BITS-1 -: ADDR_BITS]);
    assign payload = word_i[DATA_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_a_o   <= '0;
            ctl_b_o   <= '0;
            pc_lo_stg <= '0;
            pc_o      <= '0;
            sc_o      <= '0;
            commit_o  <= 1'b0;
        end else begin
            commit_o <= 1'b0;
            if (word_vld_i) begin
                unique case (addr)
                    ADR_CTL_A: ctl_a_o   <= payload;
                    ADR_CTL_B: ctl_b_o   <= payload;
                    ADR_PC_LO: pc_lo_stg <= payload;
                    ADR_SC: begin
                        sc_o     <= payload;
                        pc_o     <= {ctl_b_o[DATA_BITS-1 -: PC_HI_BITS], pc_lo_stg};
                        commit_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the divisor output changes only together with the commit strobe
    p_pc_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_o) |-> commit_o);

    // R6: the commit strobe is a single-cycle pulse
    p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    // R8: control fields hold unless a word is accepted
    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_i |=> ($stable(ctl_a_o) && $stable(ctl_b_o)));
endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
    import serial_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_data_i,
    input  logic               ser_clk_i,
    input  logic               ser_frame_i,
    output logic [2:0]         test_o,
    output logic               sw_out_o,
    output logic               cp_cur_lo_o,
    output logic               ref_sel_o,
    output logic               lf_sel_o,
    output logic               cp_cur_hi_o,
    output logic               div_mode_o,
    output logic               band_o,
    output logic               standby_o,
    output logic [PC_BITS-1:0] pc_o,
    output logic [5:0]         sc_o,
    output logic               commit_o
);
    logic [2:0]           pins_s;
    logic [WORD_BITS-1:0] word;
    logic                 word_vld;
    logic [DATA_BITS-1:0] ctl_a, ctl_b;

    serial_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_frame_i, ser_clk_i, ser_data_i}),
        .dout (pins_s)
    );

    serial_cfg_frame_rx #(.NBITS(WORD_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[1]),
        .frame_s   (pins_s[2]),
        .data_s    (pins_s[0]),
        .word_o    (word),
        .word_vld_o(word_vld)
    );

    serial_cfg_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_i    (word),
        .word_vld_i(word_vld),
        .ctl_a_o   (ctl_a),
        .ctl_b_o   (ctl_b),
        .pc_o      (pc_o),
        .sc_o      (sc_o),
        .commit_o  (commit_o)
    );

    assign test_o      = {ctl_a[3], ctl_a[4], ctl_a[5]};
    assign sw_out_o    = ctl_a[2];
    assign cp_cur_lo_o = ctl_a[1];
    assign ref_sel_o   = ctl_a[0];
    assign lf_sel_o    = ctl_b[3];
    assign cp_cur_hi_o = ctl_b[2];
    assign div_mode_o  = ctl_b[1];
    assign band_o      = ctl_b[0];
    assign standby_o   = ~(ctl_b[1] | ctl_b[0]);
endmodule

// File: tb/serial_cfg_slave_tb_top.sv
module serial_cfg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SER   = 6;
    localparam int NVEC       = 10;

    // stimulus word, falls sent, expected pc_o, sc_o, commit pulses
    localparam logic [7:0] V_WORD [NVEC] = '{8'hA5, 8'h6B, 8'hC7, 8'h07, 8'hBF,
                                             8'hC1, 8'hBF, 8'h54, 8'hEA, 8'h28};
    localparam int         V_NB   [NVEC] = '{8, 8, 8, 8, 7, 9, 8, 8, 8, 8};
    localparam logic [7:0] V_PC   [NVEC] = '{8'h00, 8'h00, 8'hA5, 8'hA5, 8'hA5,
                                             8'hA5, 8'hA5, 8'hA5, 8'h7F, 8'h7F};
    localparam logic [5:0] V_SC   [NVEC] = '{6'h00, 6'h00, 6'h07, 6'h07, 6'h07,
                                             6'h07, 6'h07, 6'h07, 6'h2A, 6'h2A};
    localparam int         V_CM   [NVEC] = '{0, 0, 1, 0, 0, 0, 0, 0, 1, 0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic sdat = 1'b0, sclk = 1'b0, sfrm = 1'b0;
    logic [2:0] test_o;
    logic sw_out_o, cp_cur_lo_o, ref_sel_o, lf_sel_o, cp_cur_hi_o;
    logic div_mode_o, band_o, standby_o, commit_o;
    logic [7:0] pc_o;
    logic [5:0] sc_o;

    int n_chk = 0, n_bad = 0, commit_cnt = 0;
    logic [5:0] m_a = '0, m_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (commit_o) commit_cnt <= commit_cnt + 1;

    serial_cfg_slave #(.SYNC_STAGES(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sdat), .ser_clk_i(sclk),
        .ser_frame_i(sfrm), .test_o(test_o), .sw_out_o(sw_out_o),
        .cp_cur_lo_o(cp_cur_lo_o), .ref_sel_o(ref_sel_o), .lf_sel_o(lf_sel_o),
        .cp_cur_hi_o(cp_cur_hi_o), .div_mode_o(div_mode_o), .band_o(band_o),
        .standby_o(standby_o), .pc_o(pc_o), .sc_o(sc_o), .commit_o(commit_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] w, input int nb);
        sfrm = 1'b1;
        wait_cyc(HALF_SER);
        for (int i = 0; i < nb; i++) begin
            sdat = (i < 8) ? w[7-i] : 1'b0;
            wait_cyc(HALF_SER);
            sclk = 1'b1;
            wait_cyc(HALF_SER);
            sclk = 1'b0;
            wait_cyc(HALF_SER);
        end
        sfrm = 1'b0;
        wait_cyc(12);
    endtask

    function automatic logic [10:0] model_ctl();
        return {m_a[3], m_a[4], m_a[5], m_a[2], m_a[1], m_a[0],
                m_b[3], m_b[2], m_b[1], m_b[0], ~(m_b[1] | m_b[0])};
    endfunction

    function automatic logic [10:0] dut_ctl();
        return {test_o, sw_out_o, cp_cur_lo_o, ref_sel_o, lf_sel_o,
                cp_cur_hi_o, div_mode_o, band_o, standby_o};
    endfunction

    function automatic string vec_req(input int i);
        case (i)
            0, 6:    return "R5 staged low divisor";
            1:       return "R4 word 01 fields";
            2, 8:    return "R6 swallow commit";
            3, 9:    return "R3 word 00 fields";
            4, 5:    return "R7 wrong length";
            7:       return "R8 standby retains";
            default: return "R2";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_cyc(5);
        // R1 reset state
        check("R1 ctl", 32'(dut_ctl()), 32'(11'h001));
        check("R1 pc", 32'(pc_o), 0);
        check("R1 sc", 32'(sc_o), 0);
        check("R1 commit", 32'(commit_o), 0);
        rst_n = 1'b1;
        wait_cyc(5);
        check("R1 after release", 32'(dut_ctl()), 32'(11'h001));

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            commit_cnt = 0;
            send(V_WORD[i], V_NB[i]);
            if (V_NB[i] == 8) begin
                if (V_WORD[i][7:6] == 2'b00) m_a = V_WORD[i][5:0];
                if (V_WORD[i][7:6] == 2'b01) m_b = V_WORD[i][5:0];
            end
            check({vec_req(i), " ctl"}, 32'(dut_ctl()), 32'(model_ctl()));
            check({vec_req(i), " pc"}, 32'(pc_o), 32'(V_PC[i]));
            check({vec_req(i), " sc"}, 32'(sc_o), 32'(V_SC[i]));
            check({vec_req(i), " commit count"}, commit_cnt, V_CM[i]);
        end

        // R9: stray clock falls outside a frame, then a valid word
        for (int k = 0; k < 5; k++) begin
            sdat = k[0];
            wait_cyc(HALF_SER); sclk = 1'b1;
            wait_cyc(HALF_SER); sclk = 1'b0;
        end
        wait_cyc(12);
        check("R9 stray edges no effect", 32'(dut_ctl()), 32'(model_ctl()));
        send(8'h5E, 8); // address 01: pc7..6=01, lpf1 cur1 1 mode1 band0
        m_b = 6'h1E;
        check("R9 word after stray edges", 32'(dut_ctl()), 32'(model_ctl()));
        check("R8 leave standby", 32'(standby_o), 0);
        check("R8 pc retained", 32'(pc_o), 32'h7F);

        // R2: latency bound and MSB-first assembly
        commit_cnt = 0;
        send(8'h80, 8);   // low divisor bits 0
        send(8'hC0 | 8'h33, 8);
        check("R2 msb-first sc", 32'(sc_o), 32'h33);
        check("R6 commit of 01/000000", 32'(pc_o), 32'h40);
        check("R6 one commit", commit_cnt, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule